// File: doc/BRIEF.md
# Display RAM Write Address Counter

This block turns a stream of byte-wide host writes into write strobes for a bit-mapped display memory of 133 columns by 65 rows. The memory is organised as nine banks: banks 0 to 7 each hold eight rows, and bank 8 holds a single icon row. A column pointer made of a 7-bit X field and a page bit selects the logical column. A 4-bit Y field selects the bank.

Separate load inputs set each pointer field. After every accepted byte the pointer advances by one column. When it passes the last column, it moves on to the next bank. A mode input reverses the order of the physical columns. Writes that fall outside the array are refused and reported on a one-cycle error pulse.

The block produces a registered write port: strobe, physical column, bank, data and a bit mask. This port drives the display memory directly. Serial bus handling and command decoding sit upstream and are not part of the block.

Top module: `dram_wr_addr`

## Requirements
- R1: The logical column is page*128 + X, which is simply {page, X}. With mirroring off, the physical column on `ram_col` equals the logical column, so X=127 page=0 gives 127 and X=0 page=1 gives 128.
- R2: With `mirror_en` high when a byte is accepted, `ram_col` is 132 minus the logical column, so logical 0 goes to 132 and logical 132 goes to 0. The mode is sampled per byte and may change between bytes.
- R3: A byte accepted at a clock edge (`wr_valid` high) shows on the write port for exactly the following cycle. `ram_bank` equals Y, and no strobe or error appears in a cycle whose previous edge saw `wr_valid` low.
- R4: For banks 0 to 7, `ram_wdata` carries the whole byte and `ram_mask` is 8'hFF. Bit i of bank b is display row 8*b+i, so bit 0 is the bank's top row.
- R5: For bank 8 (the icon row), `ram_mask` is 8'h01 and `ram_wdata` bit 0 carries the byte's MSB (bit 7). All other data bits are 0.
- R6: A byte whose logical column exceeds 132, or whose Y exceeds 8, gives no strobe. Instead `range_err` is high for one cycle, and the pointer does not advance.
- R7: After each accepted legal byte, the logical column advances by one, carrying from X=127 page=0 into page 1.
- R8: After logical column 132 the column wraps to 0 and Y increments. Y wraps from 8 back to 0.
- R9: Each load input replaces only its own field (X, page or Y) from the next cycle on. The other fields keep their values.
- R10: Synchronous reset clears X, page and Y to 0. While reset is high, no strobe and no error are produced, even if `wr_valid` is high, so reset never alters memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_x_en | input | 1 | Load X field |
| ld_x_val | input | 7 | New X value |
| ld_pg_en | input | 1 | Load page bit |
| ld_pg_val | input | 1 | New page value |
| ld_y_en | input | 1 | Load Y (bank) field |
| ld_y_val | input | 4 | New Y value |
| mirror_en | input | 1 | Reverse column order for this byte |
| wr_valid | input | 1 | Data byte present this cycle |
| wr_byte | input | 8 | Data byte |
| ram_we | output | 1 | Memory write strobe |
| ram_col | output | 8 | Physical column 0..132 |
| ram_bank | output | 4 | Bank 0..8 |
| ram_wdata | output | 8 | Data to write |
| ram_mask | output | 8 | Bits of the bank word to update |
| range_err | output | 1 | Refused out-of-array write |

## Verification
The bench targets the two pointer boundaries: the carry from column 127 into page 1, and the wrap from column 132 into the next bank and from bank 8 back to bank 0. A design that mishandles the first would write column 0 or 255 instead of 128. A design that mishandles the second would either reach into columns 133 and above or never leave the bank. Mirroring is tested at both ends of the range, where an off-by-one shows up as column 133 or a missing column 0.

The bench also writes icon-row bytes whose MSB differs from their LSB, which exposes a design that stores the wrong bit or unmasks the other seven rows. It checks that a refused write leaves the pointer where it was, which a design that advances anyway would violate. A full sweep of the array is then compared bit by bit against a reference memory.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int XW  = 7;          // X pointer width
    localparam int YW  = 4;          // bank pointer width
    localparam int DW  = 8;          // data byte width
    localparam int LCW = XW + 1;     // logical column width {page, X}

    typedef struct packed {
        logic          pg;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } wptr_t;

    typedef struct packed {
        logic           we;
        logic           err;
        logic [LCW-1:0] col;
        logic [YW-1:0]  bank;
        logic [DW-1:0]  data;
        logic [DW-1:0]  mask;
    } wreq_t;

    function automatic logic [LCW-1:0] log_col(input wptr_t p);
        return {p.pg, p.x};
    endfunction

    function automatic logic ptr_legal(input wptr_t p, input int ncol, input int nbank);
        return (int'(log_col(p)) < ncol) && (int'(p.y) < nbank);
    endfunction

    function automatic wptr_t ptr_step(input wptr_t p, input int ncol, input int nbank);
        wptr_t n;
        n = p;
        if (int'(log_col(p)) == ncol - 1) begin
            n.pg = 1'b0;
            n.x  = '0;
            n.y  = (int'(p.y) == nbank - 1) ? '0 : p.y + YW'(1);
        end else begin
            {n.pg, n.x} = log_col(p) + LCW'(1);
        end
        return n;
    endfunction

    function automatic logic [DW-1:0] bank_mask(input logic [YW-1:0] y, input int nbank);
        return (int'(y) == nbank - 1) ? DW'(1) : '1;
    endfunction

    function automatic logic [DW-1:0] bank_data(input logic [DW-1:0] b,
                                                input logic [YW-1:0] y, input int nbank);
        return (int'(y) == nbank - 1) ? DW'(b[DW-1]) : b;
    endfunction

endpackage

// File: rtl/dram_ptr_reg.sv
module dram_ptr_reg
    import dram_pkg::*;
#(
    parameter int NCOL  = 133,
    parameter int NBANK = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_x,
    input  logic [XW-1:0] x_val,
    input  logic          ld_pg,
    input  logic          pg_val,
    input  logic          ld_y,
    input  logic [YW-1:0] y_val,
    input  logic          step,
    output wptr_t         ptr_q
);

    wptr_t ptr_d;

    always_comb begin
        ptr_d = step ? ptr_step(ptr_q, NCOL, NBANK) : ptr_q;
        if (ld_x)  ptr_d.x  = x_val;
        if (ld_pg) ptr_d.pg = pg_val;
        if (ld_y)  ptr_d.y  = y_val;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/dram_col_map.sv
module dram_col_map
    import dram_pkg::*;
#(
    parameter int NCOL       = 133,
    parameter bit HAS_MIRROR = 1'b1
) (
    input  logic [LCW-1:0] log_in,
    input  logic           mirror,
    output logic [LCW-1:0] phys
);

    localparam logic [LCW-1:0] LAST = LCW'(NCOL - 1);

    generate
        if (HAS_MIRROR) begin : g_mirror
            assign phys = mirror ? (LAST - log_in) : log_in;
        end else begin : g_direct
            logic unused_mirror;
            assign unused_mirror = mirror;
            assign phys = log_in;
        end
    endgenerate

endmodule

// File: rtl/dram_wr_stage.sv
module dram_wr_stage
    import dram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req_d,
    output wreq_t req_q
);

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

endmodule

// File: rtl/dram_wr_addr.sv
module dram_wr_addr
    import dram_pkg::*;
#(
    parameter int NCOL       = 133,
    parameter int NBANK      = 9,
    parameter bit HAS_MIRROR = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_x_en,
    input  logic [XW-1:0]  ld_x_val,
    input  logic           ld_pg_en,
    input  logic           ld_pg_val,
    input  logic           ld_y_en,
    input  logic [YW-1:0]  ld_y_val,
    input  logic           mirror_en,
    input  logic           wr_valid,
    input  logic [DW-1:0]  wr_byte,
    output logic           ram_we,
    output logic [LCW-1:0] ram_col,
    output logic [YW-1:0]  ram_bank,
    output logic [DW-1:0]  ram_wdata,
    output logic [DW-1:0]  ram_mask,
    output logic           range_err
);

    wptr_t          ptr_q;
    logic           legal;
    logic           step;
    logic [LCW-1:0] phys_col;
    wreq_t          req_d;
    wreq_t          req_q;

    assign legal = ptr_legal(ptr_q, NCOL, NBANK);
    assign step  = wr_valid && legal;

    dram_ptr_reg #(.NCOL(NCOL), .NBANK(NBANK)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld_x   (ld_x_en),
        .x_val  (ld_x_val),
        .ld_pg  (ld_pg_en),
        .pg_val (ld_pg_val),
        .ld_y   (ld_y_en),
        .y_val  (ld_y_val),
        .step   (step),
        .ptr_q  (ptr_q)
    );

    dram_col_map #(.NCOL(NCOL), .HAS_MIRROR(HAS_MIRROR)) u_map (
        .log_in (log_col(ptr_q)),
        .mirror (mirror_en),
        .phys   (phys_col)
    );

    always_comb begin
        req_d      = '0;
        req_d.we   = step;
        req_d.err  = wr_valid && !legal;
        req_d.col  = phys_col;
        req_d.bank = ptr_q.y;
        req_d.data = bank_data(wr_byte, ptr_q.y, NBANK);
        req_d.mask = bank_mask(ptr_q.y, NBANK);
    end

    dram_wr_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .req_d (req_d),
        .req_q (req_q)
    );

    assign ram_we    = req_q.we;
    assign range_err = req_q.err;
    assign ram_col   = req_q.col;
    assign ram_bank  = req_q.bank;
    assign ram_wdata = req_q.data;
    assign ram_mask  = req_q.mask;

endmodule

// File: rtl/dram_wr_addr_chk.sv
module dram_wr_addr_chk
    import dram_pkg::*;
#(
    parameter int NCOL  = 133,
    parameter int NBANK = 9
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_valid,
    input logic           ld_x_en,
    input logic           ld_pg_en,
    input logic           ld_y_en,
    input logic           ram_we,
    input logic           range_err,
    input logic [LCW-1:0] ram_col,
    input logic [YW-1:0]  ram_bank,
    input logic [DW-1:0]  ram_mask,
    input wptr_t          ptr_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R10
    always_comb begin
        if (rst_d === 1'b1) begin
            reset_quiet_chk: assert (!ram_we && !range_err);
        end
    end

    // R3
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !(ram_we || range_err));

    // R6
    we_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && range_err));

    // R2
    col_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (int'(ram_col) < NCOL) && (int'(ram_bank) < NBANK));

    // R5
    icon_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && int'(ram_bank) == NBANK - 1) |-> ram_mask == DW'(1));

    // R4
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && int'(ram_bank) < NBANK - 1) |-> ram_mask == '1);

    // R6
    err_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (range_err && !$past(ld_x_en || ld_pg_en || ld_y_en)) |-> ptr_q == $past(ptr_q));

endmodule

bind dram_wr_addr dram_wr_addr_chk #(.NCOL(NCOL), .NBANK(NBANK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .ld_x_en   (ld_x_en),
    .ld_pg_en  (ld_pg_en),
    .ld_y_en   (ld_y_en),
    .ram_we    (ram_we),
    .range_err (range_err),
    .ram_col   (ram_col),
    .ram_bank  (ram_bank),
    .ram_mask  (ram_mask),
    .ptr_q     (ptr_q)
);

// File: tb/dram_wr_addr_tb.sv
module dram_wr_addr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_x_en = 1'b0, ld_pg_en = 1'b0, ld_y_en = 1'b0;
    logic [6:0] ld_x_val = '0;
    logic       ld_pg_val = 1'b0;
    logic [3:0] ld_y_val = '0;
    logic       mirror_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       ram_we, range_err;
    logic [7:0] ram_col, ram_wdata, ram_mask;
    logic [3:0] ram_bank;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench pointer model
    int mx = 0, mp = 0, my = 0;

    logic [7:0] dut_mem [0:8][0:132];
    logic [7:0] exp_mem [0:8][0:132];

    dram_wr_addr u_dut (
        .clk(clk), .rst(rst),
        .ld_x_en(ld_x_en), .ld_x_val(ld_x_val),
        .ld_pg_en(ld_pg_en), .ld_pg_val(ld_pg_val),
        .ld_y_en(ld_y_en), .ld_y_val(ld_y_val),
        .mirror_en(mirror_en), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .ram_we(ram_we), .ram_col(ram_col), .ram_bank(ram_bank),
        .ram_wdata(ram_wdata), .ram_mask(ram_mask), .range_err(range_err)
    );

    always #2 clk = ~clk;

    // behavioural display memory fed by the write port
    always @(posedge clk) begin
        if (ram_we === 1'b1 && ram_bank <= 4'd8 && ram_col <= 8'd132)
            dut_mem[ram_bank][ram_col] <= (dut_mem[ram_bank][ram_col] & ~ram_mask)
                                          | (ram_wdata & ram_mask);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load(input bit dx, input int x, input bit dp, input int p,
                        input bit dy, input int y);
        @(negedge clk);
        ld_x_en = dx; ld_x_val = 7'(x);
        ld_pg_en = dp; ld_pg_val = p[0];
        ld_y_en = dy; ld_y_val = 4'(y);
        @(negedge clk);
        ld_x_en = 0; ld_pg_en = 0; ld_y_en = 0;
        if (dx) mx = x;
        if (dp) mp = p;
        if (dy) my = y;
    endtask

    // one byte; expected result computed from the pointer model
    task automatic wr(input logic [7:0] b, input bit mir, input string req);
        int  lc    = mp * 128 + mx;
        bit  legal = (lc <= 132) && (my <= 8);
        int  phys  = mir ? 132 - lc : lc;
        logic [7:0] emask = (my == 8) ? 8'h01 : 8'hFF;
        logic [7:0] edata = (my == 8) ? {7'b0, b[7]} : b;
        @(negedge clk);
        wr_valid = 1; wr_byte = b; mirror_en = mir;
        @(negedge clk);
        wr_valid = 0;
        if (legal) begin
            chk(ram_we === 1'b1 && range_err === 1'b0, req, "strobe", int'(ram_we), 1);
            chk(ram_col === 8'(phys), req, "column", int'(ram_col), phys);
            chk(ram_bank === 4'(my), req, "bank", int'(ram_bank), my);
            chk(ram_mask === emask, req, "mask", int'(ram_mask), int'(emask));
            chk((ram_wdata & ram_mask) === edata, req, "data",
                int'(ram_wdata & ram_mask), int'(edata));
            exp_mem[my][phys] = (exp_mem[my][phys] & ~emask) | edata;
            if (lc == 132) begin
                lc = 0;
                my = (my == 8) ? 0 : my + 1;
            end else lc++;
            mx = lc % 128; mp = lc / 128;
        end else begin
            chk(ram_we === 1'b0 && range_err === 1'b1, req, "refused write err",
                int'(range_err), 1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1; wr_valid = 1; wr_byte = 8'hFF;
        repeat (3) @(negedge clk);
        chk(ram_we === 1'b0 && range_err === 1'b0, "R10", "quiet in reset",
            int'(ram_we), 0);
        wr_valid = 0; rst = 0;
        mx = 0; mp = 0; my = 0;
        @(negedge clk);
        chk(ram_we === 1'b0, "R3", "no strobe when idle", int'(ram_we), 0);
        wr(8'hA5, 0, "R10");
    endtask

    task automatic t_seq();
        wr(8'h01, 0, "R7");
        wr(8'h80, 0, "R7");
        wr(8'h3C, 0, "R4");
    endtask

    task automatic t_page();
        load(1, 126, 1, 0, 1, 3);
        wr(8'h11, 0, "R1");
        wr(8'h22, 0, "R1");
        wr(8'h33, 0, "R7");
    endtask

    task automatic t_wrap();
        load(1, 3, 1, 1, 1, 5);
        wr(8'h44, 0, "R8");
        wr(8'h55, 0, "R8");
        wr(8'h66, 0, "R8");
        load(1, 4, 1, 1, 1, 8);
        wr(8'h80, 0, "R5");
        wr(8'h77, 0, "R8");
    endtask

    task automatic t_mirror();
        load(1, 0, 1, 0, 1, 1);
        wr(8'h9A, 1, "R2");
        wr(8'h9B, 1, "R2");
        wr(8'h9C, 0, "R2");
        load(1, 4, 1, 1, 0, 0);
        wr(8'h9D, 1, "R2");
    endtask

    task automatic t_icon();
        load(1, 10, 1, 0, 1, 8);
        wr(8'h7F, 0, "R5");
        wr(8'hC3, 0, "R5");
        wr(8'h01, 1, "R5");
    endtask

    task automatic t_illegal();
        load(1, 5, 1, 1, 1, 0);
        wr(8'hEE, 0, "R6");
        @(negedge clk);
        chk(range_err === 1'b0, "R6", "error lasts one cycle", int'(range_err), 0);
        load(1, 100, 1, 0, 1, 9);
        wr(8'hEF, 0, "R6");
        load(0, 0, 0, 0, 1, 2);
        wr(8'hF0, 0, "R6");
        load(1, 50, 0, 0, 0, 0);
        wr(8'hF1, 0, "R9");
    endtask

    task automatic t_sweep();
        load(1, 0, 1, 0, 1, 0);
        for (int i = 0; i < 133 * 9; i++) wr(8'(i * 37 + 5), 0, "R4");
        repeat (2) @(negedge clk);
        for (int b = 0; b < 9; b++)
            for (int c = 0; c < 133; c++)
                for (int i = 0; i < 8; i++)
                    if (b < 8 || i == 0)
                        chk(dut_mem[b][c][i] === exp_mem[b][c][i], "R4",
                            $sformatf("row %0d col %0d", b * 8 + i, c),
                            int'(dut_mem[b][c][i]), int'(exp_mem[b][c][i]));
    endtask

    initial begin
        for (int b = 0; b < 9; b++)
            for (int c = 0; c < 133; c++) begin
                dut_mem[b][c] = '0;
                exp_mem[b][c] = '0;
            end
        t_reset();
        t_seq();
        t_page();
        t_wrap();
        t_mirror();
        t_icon();
        t_illegal();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog run hung actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule